// File: doc/BRIEF.md
# Host Byte-Cycle Engine for the Low Pin Count Bus

This block is the host end of a Low Pin Count (LPC) bus. It runs one single-byte memory or I/O cycle at a time. A requester presents a cycle kind, a direction, an address and, for writes, a data byte. The engine then steps the four-bit multiplexed bus and the frame strobe through every phase of the cycle. These phases are the opening marker, the type code, the address nibbles, the data nibbles, the bus hand-over clocks and the peripheral's readiness handshake. When the cycle completes, the engine reports the read byte together with an error flag.

A wider transfer is the requester's job: it issues one byte cycle per byte. After each cycle the engine spends at least one clock idle before it will accept the next request. While the peripheral answers, the engine counts clocks in which no ready code has arrived. When that count passes a limit held on an input, the engine abandons the cycle and reports an error. The pad tri-state is not modelled. Instead the engine exposes a drive-enable that tells the pad when the host owns the nibble lines.

Top module: `lpc_host_engine`

## Requirements
- R1: While reset is held and in the first clock after it, `lframe_n` is 1, `lad_oe` is 0, `lad_out` is 1111b, `req_ready` is 1 and `done` is 0.
- R2: In the first clock after the edge that accepts a request, `lframe_n` is 0 and `lad_out` is 0000b with `lad_oe` set. `lframe_n` is low for that single clock and high in every other clock.
- R3: The next clock carries the type code {0, is_mem, write, 0}: I/O read 0000b, I/O write 0010b, memory read 0100b, memory write 0110b.
- R4: The address follows, most significant nibble first. A memory cycle sends all 32 bits as 8 nibbles. An I/O cycle sends only bits 15:0 as 4 nibbles, and bits 31:16 have no effect on the bus.
- R5: A write sends the data byte low nibble first, then drives 1111b for one clock, then releases the bus (`lad_oe` 0) for one clock.
- R6: A read drives 1111b for one clock straight after the address, then releases the bus for one clock.
- R7: In the readiness phase the host does not drive. A sampled `lad_in` of 0000b means ready. Any other value, including the wait codes 0101b and 0110b, is counted as a wait clock.
- R8: On a read, the two clocks after the ready clock carry the byte from the peripheral, low nibble first. The byte appears on `rdata` while `done` is high.
- R9: After the data phase (read) or the ready clock (write), the bus stays released for two clocks. `done` is then high for exactly one clock with `err` at 0.
- R10: If the readiness phase sees `sync_limit`+1 consecutive non-ready clocks, the cycle ends. In the next clock `done` and `err` are both 1, the bus is released and `lframe_n` is high. Exactly `sync_limit` wait clocks followed by a ready clock complete normally.
- R11: `req_ready` is high only when the engine is idle. A request raised while a cycle is in progress has no effect on the bus. Consecutive cycles are separated by at least one clock with `lframe_n` high and the bus released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle; a request is taken on this edge |
| req_is_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address (I/O uses bits 15:0) |
| req_wdata | input | 8 | Byte to write |
| sync_limit | input | 8 | Tolerated non-ready readiness clocks |
| lad_in | input | 4 | Nibble lines as seen from the bus |
| lad_out | output | 4 | Nibble the host drives |
| lad_oe | output | 1 | Host drives the nibble lines |
| lframe_n | output | 1 | Active-low cycle frame strobe |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Completion was a readiness timeout |
| rdata | output | 8 | Byte returned by a read |

## Verification
Each bus output is a decode of registered state. The opening marker is therefore due one clock after the accepting edge, and every later phase follows one clock per nibble. `done`, `err` and `rdata` are due in the clock after the last released turnaround clock, or in the clock after the final non-ready readiness sample. The bench's reference model builds, for every request, a queue of the expected bus word and of the peripheral's reply for each clock. It applies a reply at the falling edge so the engine samples it at the next rising edge, and it compares the outputs at each falling edge. The model checks the completion values in the one idle clock that follows. The next request is issued in that same idle clock, so the minimum gap is also exercised.

// File: rtl/lpc_host_pkg.sv
package lpc_host_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_CTDIR,
        ST_ADDR,
        ST_WDATA,
        ST_HTAR1,
        ST_HTAR2,
        ST_SYNC,
        ST_RDATA,
        ST_PTAR1,
        ST_PTAR2
    } lpc_state_e;

    localparam logic [3:0] LAD_START  = 4'h0;
    localparam logic [3:0] LAD_FLOAT  = 4'hF;
    localparam logic [3:0] SYNC_READY = 4'h0;

    // type/direction nibble: {0, memory, write, 0}
    function automatic logic [3:0] cyc_code(input logic is_mem, input logic wr);
        return {1'b0, is_mem, wr, 1'b0};
    endfunction

endpackage

// File: rtl/lpc_nibble_sel.sv
module lpc_nibble_sel #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  idx,
    output logic [3:0]        addr_nib,
    output logic [3:0]        data_nib
);
    localparam int A_NIBS = ADDR_W / 4;
    localparam int D_NIBS = DATA_W / 4;
    localparam int D_IW   = $clog2(D_NIBS);

    logic [3:0] a_arr [A_NIBS];
    logic [3:0] d_arr [D_NIBS];

    for (genvar g = 0; g < A_NIBS; g++) begin : g_anib
        assign a_arr[g] = addr[g*4 +: 4];
    end
    for (genvar g = 0; g < D_NIBS; g++) begin : g_dnib
        assign d_arr[g] = wdata[g*4 +: 4];
    end

    assign addr_nib = a_arr[idx];
    assign data_nib = d_arr[idx[D_IW-1:0]];
endmodule

// File: rtl/lpc_sync_watch.sv
module lpc_sync_watch
    import lpc_host_pkg::*;
#(
    parameter int LIMIT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_sync,
    input  logic [3:0]         lad_in,
    input  logic [LIMIT_W-1:0] limit,
    output logic               sync_ok,
    output logic               expired
);
    logic [LIMIT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        sync_ok = in_sync && (lad_in == SYNC_READY);
        expired = in_sync && !sync_ok && (cnt_q == limit);
        cnt_d   = '0;
        if (in_sync && !sync_ok && !expired) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_sync |-> (cnt_q <= limit));

    // R7
    ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_ok |=> (cnt_q == '0));
endmodule

// File: rtl/lpc_host_fsm.sv
module lpc_host_fsm
    import lpc_host_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int IO_ADDR_W = 16,
    parameter int DATA_W    = 8,
    parameter int CNT_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_is_mem,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [3:0]        lad_in,
    input  logic              sync_ok,
    input  logic              sync_expired,
    input  logic [3:0]        addr_nib,
    input  logic [3:0]        data_nib,
    output logic              in_sync,
    output logic [CNT_W-1:0]  nib_idx,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              req_ready,
    output logic              lframe_n,
    output logic [3:0]        lad_out,
    output logic              lad_oe,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata
);
    localparam int MEM_NIBS = ADDR_W / 4;
    localparam int IO_NIBS  = IO_ADDR_W / 4;
    localparam int DATA_NIBS = DATA_W / 4;
    localparam logic [CNT_W-1:0] MEM_LAST  = CNT_W'(MEM_NIBS - 1);
    localparam logic [CNT_W-1:0] IO_LAST   = CNT_W'(IO_NIBS - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_NIBS - 1);

    typedef struct packed {
        lpc_state_e        state;
        logic [CNT_W-1:0]  nib;
        logic              is_mem;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              done;
        logic              err;
    } fsm_s;

    fsm_s s_q, s_d;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.state  = ST_START;
                    s_d.is_mem = req_is_mem;
                    s_d.wr     = req_write;
                    s_d.addr   = req_addr;
                    s_d.wdata  = req_wdata;
                    s_d.rdata  = '0;
                end
            end
            ST_START: s_d.state = ST_CTDIR;
            ST_CTDIR: begin
                s_d.state = ST_ADDR;
                s_d.nib   = s_q.is_mem ? MEM_LAST : IO_LAST;
            end
            ST_ADDR: begin
                if (s_q.nib == '0) begin
                    s_d.state = s_q.wr ? ST_WDATA : ST_HTAR1;
                end else begin
                    s_d.nib = s_q.nib - 1'b1;
                end
            end
            ST_WDATA: begin
                if (s_q.nib == DATA_LAST) begin
                    s_d.state = ST_HTAR1;
                    s_d.nib   = '0;
                end else begin
                    s_d.nib = s_q.nib + 1'b1;
                end
            end
            ST_HTAR1: s_d.state = ST_HTAR2;
            ST_HTAR2: s_d.state = ST_SYNC;
            ST_SYNC: begin
                if (sync_ok) begin
                    s_d.state = s_q.wr ? ST_PTAR1 : ST_RDATA;
                    s_d.nib   = '0;
                end else if (sync_expired) begin
                    s_d.state = ST_IDLE;
                    s_d.done  = 1'b1;
                    s_d.err   = 1'b1;
                end
            end
            ST_RDATA: begin
                s_d.rdata[int'(s_q.nib)*4 +: 4] = lad_in;
                if (s_q.nib == DATA_LAST) begin
                    s_d.state = ST_PTAR1;
                    s_d.nib   = '0;
                end else begin
                    s_d.nib = s_q.nib + 1'b1;
                end
            end
            ST_PTAR1: s_d.state = ST_PTAR2;
            ST_PTAR2: begin
                s_d.state = ST_IDLE;
                s_d.done  = 1'b1;
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    // bus outputs decoded from registered state only
    always_comb begin
        lframe_n = 1'b1;
        lad_oe   = 1'b0;
        lad_out  = LAD_FLOAT;
        unique case (s_q.state)
            ST_START: begin
                lframe_n = 1'b0;
                lad_oe   = 1'b1;
                lad_out  = LAD_START;
            end
            ST_CTDIR: begin
                lad_oe  = 1'b1;
                lad_out = cyc_code(s_q.is_mem, s_q.wr);
            end
            ST_ADDR: begin
                lad_oe  = 1'b1;
                lad_out = addr_nib;
            end
            ST_WDATA: begin
                lad_oe  = 1'b1;
                lad_out = data_nib;
            end
            ST_HTAR1: lad_oe = 1'b1;
            default: ;
        endcase
    end

    assign in_sync   = (s_q.state == ST_SYNC);
    assign nib_idx   = s_q.nib;
    assign addr_o    = s_q.addr;
    assign wdata_o   = s_q.wdata;
    assign req_ready = (s_q.state == ST_IDLE);
    assign done      = s_q.done;
    assign err       = s_q.err;
    assign rdata     = s_q.rdata;

    // R2
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lframe_n |=> lframe_n);

    // R11
    idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lframe_n |-> ($past(lframe_n) && !$past(lad_oe)));

    // R7
    sync_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_sync |-> !lad_oe);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && lframe_n && !lad_oe));

    // R11
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lad_oe |-> !req_ready);
endmodule

// File: rtl/lpc_host_engine.sv
module lpc_host_engine
    import lpc_host_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int IO_ADDR_W = 16,
    parameter int DATA_W    = 8,
    parameter int LIMIT_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_is_mem,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [LIMIT_W-1:0] sync_limit,
    input  logic [3:0]         lad_in,
    output logic [3:0]         lad_out,
    output logic               lad_oe,
    output logic               lframe_n,
    output logic               done,
    output logic               err,
    output logic [DATA_W-1:0]  rdata
);
    localparam int CNT_W = $clog2(ADDR_W / 4);

    logic              in_sync, sync_ok, sync_expired;
    logic [CNT_W-1:0]  nib_idx;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [3:0]        addr_nib, data_nib;

    lpc_host_fsm #(
        .ADDR_W(ADDR_W), .IO_ADDR_W(IO_ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_is_mem(req_is_mem), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .lad_in(lad_in),
        .sync_ok(sync_ok), .sync_expired(sync_expired),
        .addr_nib(addr_nib), .data_nib(data_nib),
        .in_sync(in_sync), .nib_idx(nib_idx), .addr_o(addr_q), .wdata_o(wdata_q),
        .req_ready(req_ready), .lframe_n(lframe_n), .lad_out(lad_out),
        .lad_oe(lad_oe), .done(done), .err(err), .rdata(rdata)
    );

    lpc_nibble_sel #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
    ) u_nib (
        .addr(addr_q), .wdata(wdata_q), .idx(nib_idx),
        .addr_nib(addr_nib), .data_nib(data_nib)
    );

    lpc_sync_watch #(
        .LIMIT_W(LIMIT_W)
    ) u_sync (
        .clk(clk), .rst_n(rst_n), .in_sync(in_sync), .lad_in(lad_in),
        .limit(sync_limit), .sync_ok(sync_ok), .expired(sync_expired)
    );
endmodule

// File: tb/lpc_host_engine_tb.sv
module lpc_host_engine_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_is_mem = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  sync_limit = 8'd4;
    logic [3:0]  lad_in = 4'hF;
    logic [3:0]  lad_out;
    logic        lad_oe;
    logic        lframe_n;
    logic        done;
    logic        err;
    logic [7:0]  rdata;

    int total = 0;
    int bad = 0;

    always #(CLK_P/2) clk = ~clk;

    lpc_host_engine u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_is_mem(req_is_mem), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .sync_limit(sync_limit), .lad_in(lad_in),
        .lad_out(lad_out), .lad_oe(lad_oe), .lframe_n(lframe_n),
        .done(done), .err(err), .rdata(rdata)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // reference model: per-clock expected {lframe_n, lad_oe, lad_out}
    // and the peripheral's reply for that clock
    task automatic run_cycle(input bit mem, input bit wr, input logic [31:0] a,
                             input logic [7:0] d, input int nwait,
                             input bit tmo, input logic [7:0] lim, input bit poke);
        logic [5:0] eo[$];
        logic [3:0] ein[$];
        string      etag[$];
        int         nn;
        eo.push_back({1'b0, 1'b1, 4'h0}); ein.push_back(4'hF); etag.push_back("R2 start");
        eo.push_back({1'b1, 1'b1, 1'b0, mem, wr, 1'b0}); ein.push_back(4'hF);
        etag.push_back("R3 type");
        nn = mem ? 8 : 4;
        for (int i = nn - 1; i >= 0; i--) begin
            eo.push_back({1'b1, 1'b1, a[i*4 +: 4]}); ein.push_back(4'hF);
            etag.push_back("R4 addr");
        end
        if (wr) begin
            eo.push_back({1'b1, 1'b1, d[3:0]}); ein.push_back(4'hF); etag.push_back("R5 data lo");
            eo.push_back({1'b1, 1'b1, d[7:4]}); ein.push_back(4'hF); etag.push_back("R5 data hi");
            eo.push_back({1'b1, 1'b1, 4'hF});   ein.push_back(4'hF); etag.push_back("R5 tar drive");
            eo.push_back({1'b1, 1'b0, 4'hF});   ein.push_back(4'hF); etag.push_back("R5 tar float");
        end else begin
            eo.push_back({1'b1, 1'b1, 4'hF}); ein.push_back(4'hF); etag.push_back("R6 tar drive");
            eo.push_back({1'b1, 1'b0, 4'hF}); ein.push_back(4'hF); etag.push_back("R6 tar float");
        end
        if (tmo) begin
            for (int k = 0; k <= int'(lim); k++) begin
                eo.push_back({1'b1, 1'b0, 4'hF});
                ein.push_back((k % 3 == 2) ? 4'hF : ((k % 2 == 0) ? 4'h6 : 4'h5));
                etag.push_back("R10 sync wait");
            end
        end else begin
            for (int k = 0; k < nwait; k++) begin
                eo.push_back({1'b1, 1'b0, 4'hF});
                ein.push_back((k % 2 == 0) ? 4'h5 : 4'h6);
                etag.push_back("R7 sync wait");
            end
            eo.push_back({1'b1, 1'b0, 4'hF}); ein.push_back(4'h0); etag.push_back("R7 sync ready");
            if (!wr) begin
                eo.push_back({1'b1, 1'b0, 4'hF}); ein.push_back(d[3:0]); etag.push_back("R8 rdata lo");
                eo.push_back({1'b1, 1'b0, 4'hF}); ein.push_back(d[7:4]); etag.push_back("R8 rdata hi");
            end
            eo.push_back({1'b1, 1'b0, 4'hF}); ein.push_back(4'hF); etag.push_back("R9 ptar1");
            eo.push_back({1'b1, 1'b0, 4'hF}); ein.push_back(4'hF); etag.push_back("R9 ptar2");
        end

        // caller is at a falling edge with the engine idle
        chk("R11 ready when idle", int'(req_ready), 1);
        req_valid  = 1'b1;
        req_is_mem = mem;
        req_write  = wr;
        req_addr   = a;
        req_wdata  = d;
        sync_limit = lim;
        for (int i = 0; i < eo.size(); i++) begin
            @(negedge clk);
            req_valid = poke;
            if (poke) begin
                req_addr  = ~a;
                req_wdata = ~d;
                req_write = ~wr;
            end
            lad_in = ein[i];
            chk(etag[i], int'({lframe_n, lad_oe, lad_out}), int'(eo[i]));
            chk("R11 busy not ready", int'(req_ready), 0);
            chk("R9 no early done", int'(done), 0);
        end
        @(negedge clk);
        req_valid = 1'b0;
        lad_in    = 4'hF;
        chk(tmo ? "R10 done" : "R9 done", int'(done), 1);
        chk(tmo ? "R10 err" : "R9 err", int'(err), tmo ? 1 : 0);
        chk("R11 idle bus", int'({lframe_n, lad_oe}), 2'b10);
        if (!wr && !tmo) chk("R8 rdata", int'(rdata), int'(d));
    endtask

    initial begin
        #(CLK_P * 20000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset bus", int'({lframe_n, lad_oe, lad_out}), 6'b10_1111);
        chk("R1 reset ready", int'(req_ready), 1);
        chk("R1 reset done", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset bus", int'({lframe_n, lad_oe, lad_out}), 6'b10_1111);
        chk("R1 after reset done", int'(done), 0);

        // back-to-back requests, each issued in the idle clock of the previous
        run_cycle(1'b1, 1'b1, 32'hA5C3_1E7F, 8'h3C, 0, 1'b0, 8'd4, 1'b0);
        run_cycle(1'b1, 1'b0, 32'h1234_5678, 8'h9B, 2, 1'b0, 8'd4, 1'b0);
        run_cycle(1'b0, 1'b1, 32'hFFFF_BEEF, 8'h81, 1, 1'b0, 8'd4, 1'b0);
        // exactly limit waits still complete
        run_cycle(1'b0, 1'b0, 32'h0000_0C2A, 8'h4E, 3, 1'b0, 8'd3, 1'b0);
        // timeouts
        run_cycle(1'b0, 1'b0, 32'h0000_0300, 8'h00, 0, 1'b1, 8'd2, 1'b0);
        run_cycle(1'b1, 1'b1, 32'hDEAD_0001, 8'h55, 0, 1'b1, 8'd0, 1'b0);
        // request held and altered while busy must not disturb the cycle
        run_cycle(1'b0, 1'b1, 32'h0000_70F1, 8'hC6, 0, 1'b0, 8'd1, 1'b1);
        run_cycle(1'b1, 1'b0, 32'h8000_00FF, 8'hE7, 1, 1'b0, 8'd1, 1'b0);

        repeat (2) @(negedge clk);
        chk("R11 stays idle", int'({lframe_n, lad_oe}), 2'b10);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule